// File: doc/BRIEF.md
# Pulse-Interval Charge Window Sequencer

This block sequences the two analog switches of a time-to-voltage front end that compares two once-per-second pulse trains. A rising edge on the reference pulse opens a charge window: the current-steering switch is released so a constant current ramps a capacitor, and the capacitor short is released. A rising edge on the compared pulse closes the window, and the capacitor then holds its voltage. A one-cycle interrupt tells the processor to start its conversion. When the processor acknowledges that the conversion is done, the short is applied again and the capacitor returns to zero until the next reference edge.

Both pulse inputs are asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector. A saturating counter measures the window length in clock cycles and flags windows that reach its ceiling. A reference edge that arrives before the previous sample has been acknowledged is dropped and recorded in a sticky flag. Every pin is a plain control or status line. The block has no streaming interface, so no pin carries valid/ready back-pressure.

Top module: `pps_charge_seq`

## Requirements
- R1: During and immediately after reset, charge_en_o=0, discharge_en_o=1, conv_irq_o=0, overrun_o=0, overrange_o=0 and win_len_o=0.
- R2: A rising edge on ref_pulse_i accepted while idle sets charge_en_o=1 and discharge_en_o=0 three rising clock edges after the input changes (two synchronizer flops plus the state register). If the compared edge lands in the same synchronized cycle, charge_en_o stays 0.
- R3: A synchronized rising edge on cmp_pulse_i clears charge_en_o. win_len_o then equals the number of clock cycles between the two input edges.
- R4: conv_irq_o is high for exactly one cycle, in the same cycle that charge_en_o falls. It also pulses for a zero-length window where both edges coincide.
- R5: After a window closes, discharge_en_o stays 0 (hold) until conv_done_i is sampled high. It becomes 1 on the next clock edge.
- R6: conv_done_i is ignored while charge_en_o=1: discharge_en_o stays 0 through the end of that window.
- R7: A reference edge that arrives while a sample is still held (discharge_en_o=0) is ignored. It sets overrun_o, which stays 1 until reset.
- R8: The window counter saturates at 2^CNT_W-1. overrange_o is 1 when a window reaches that value, and both are cleared when the next window is accepted.
- R9: A compared edge that arrives with no window open changes no output and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| ref_pulse_i | input | 1 | Asynchronous reference pulse; its rising edge opens a window |
| cmp_pulse_i | input | 1 | Asynchronous compared pulse; its rising edge closes a window |
| conv_done_i | input | 1 | Processor acknowledge that the held voltage has been converted |
| charge_en_o | output | 1 | High while current is steered into the capacitor |
| discharge_en_o | output | 1 | High while the capacitor short is applied |
| conv_irq_o | output | 1 | One-cycle conversion request at the end of a window |
| overrun_o | output | 1 | Sticky: a reference edge was dropped during hold |
| overrange_o | output | 1 | Last window reached the counter ceiling |
| win_len_o | output | CNT_W | Length of the current or last window in clock cycles |

## Verification
Pulse inputs are driven on falling clock edges, and all outputs are sampled on falling edges. Each pulse edge reaches the state bits on the third rising edge after it is driven. The charge check is therefore taken three samples after the reference edge, and the interrupt check three samples after the compared edge, in the sample where the charge line must already be low. The acknowledge is a synchronous input, so discharge is checked on the very next sample after conv_done_i. Window length and range flags are checked only after the window has settled.

// File: rtl/pps_seq_pkg.sv
package pps_seq_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned CNT_W_DEF      = 8;

  typedef struct packed {
    logic start;   // accepted reference edge
    logic close;   // window-ending compared edge
    logic drop;    // reference edge refused during hold
  } seq_evt_t;
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[LAST];
  end

  assign rise_o = sh_q[LAST] & ~prev_q;

  // R2: an edge pulse lasts a single cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pps_win_counter.sv
module pps_win_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  logic [CNT_W-1:0] nxt;

  assign nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (inc_i && cnt_q != MAX_CNT) begin
      cnt_q <= nxt;
      if (nxt == MAX_CNT) ovr_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovr_o = ovr_q;

  // R8: once at the ceiling, further counting keeps it there
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_CNT && inc_i && !clr_i) |=> (cnt_q == MAX_CNT));
  // R8: the ceiling is never reached without the range flag
  p_sat_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_CNT) |-> ovr_q);
endmodule

// File: rtl/pps_charge_seq.sv
module pps_charge_seq
  import pps_seq_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter int unsigned CNT_W      = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse_i,
  input  logic             cmp_pulse_i,
  input  logic             conv_done_i,
  output logic             charge_en_o,
  output logic             discharge_en_o,
  output logic             conv_irq_o,
  output logic             overrun_o,
  output logic             overrange_o,
  output logic [CNT_W-1:0] win_len_o
);
  logic     ref_rise, cmp_rise;
  logic     charge_q, hold_q, irq_q, overrun_q;
  seq_evt_t evt;

  pps_sync_edge #(.STAGES(SYNC_DEPTH)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ref_pulse_i), .rise_o(ref_rise));

  pps_sync_edge #(.STAGES(SYNC_DEPTH)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_pulse_i), .rise_o(cmp_rise));

  always_comb begin
    evt.start = ref_rise & ~hold_q;
    evt.drop  = ref_rise &  hold_q;
    evt.close = cmp_rise & (charge_q | evt.start);
  end

  // charge bit: set by accepted reference, cleared by compared edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         charge_q <= 1'b0;
    else if (cmp_rise)  charge_q <= 1'b0;
    else if (evt.start) charge_q <= 1'b1;
  end

  // hold bit: set by accepted reference, cleared only by acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hold_q <= 1'b0;
    else if (evt.start)                hold_q <= 1'b1;
    else if (conv_done_i && !charge_q) hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      irq_q <= evt.close;
      if (evt.drop) overrun_q <= 1'b1;
    end
  end

  pps_win_counter #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clr_i(evt.start), .inc_i(charge_q),
    .cnt_o(win_len_o), .ovr_o(overrange_o));

  assign charge_en_o    = charge_q;
  assign discharge_en_o = ~hold_q;
  assign conv_irq_o     = irq_q;
  assign overrun_o      = overrun_q;

  // R2: short is never applied while the capacitor is charging
  p_no_short_in_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    charge_en_o |-> !discharge_en_o);
  // R4: end of a charge window always raises the interrupt
  p_irq_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(charge_q) |-> irq_q);
  // R4: interrupt is a single-cycle pulse
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R5: hold persists until acknowledged
  p_hold_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !conv_done_i) |=> hold_q);
  // R7: overrun flag is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |=> overrun_q);
  // R7: a refused reference edge never opens a window
  p_drop_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && hold_q && !charge_q) |=> !charge_q);
endmodule

// File: tb/pps_charge_seq_tb.sv
module pps_charge_seq_tb;
  localparam int CNT_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NV    = 6;
  localparam int VEC_GAP [NV] = '{0, 1, 5, 300, 17, 100};
  localparam int VEC_LEN [NV] = '{0, 1, 5, 255, 17, 100};
  localparam int VEC_OVR [NV] = '{0, 0, 0, 1,   0,  0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0, cmp_p = 1'b0, done = 1'b0;
  logic charge, discharge, irq, overrun, overrange;
  logic [CNT_W-1:0] len;

  int tests = 0, fails = 0, irq_seen = 0;

  always #4 clk = ~clk;

  pps_charge_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .cmp_pulse_i(cmp_p),
    .conv_done_i(done), .charge_en_o(charge), .discharge_en_o(discharge),
    .conv_irq_o(irq), .overrun_o(overrun), .overrange_o(overrange),
    .win_len_o(len));

  always @(negedge clk) if (irq === 1'b1) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_window(input int gap, input bit ack, input int done_at);
    int irq0;
    irq0 = irq_seen;
    for (int c = 0; c <= gap + 8; c++) begin
      if (c == 3) begin
        chk("R2 charge on", int'(charge), (gap > 0) ? 1 : 0);
        chk("R2 discharge off", int'(discharge), 0);
      end
      if (c == gap + 3) begin
        chk("R4 irq timing", int'(irq), 1);
        chk("R3 charge off", int'(charge), 0);
      end
      if (c == 0) ref_p = 1'b1;
      if (c == 4) ref_p = 1'b0;
      if (c == gap) cmp_p = 1'b1;
      if (c == gap + 4) cmp_p = 1'b0;
      if (c == done_at) done = 1'b1;
      if (c == done_at + 1) done = 1'b0;
      @(negedge clk);
    end
    chk("R4 one irq", irq_seen - irq0, 1);
    chk("R5 held", int'(discharge), 0);
    if (ack) begin
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R5 discharge after done", int'(discharge), 1);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 charge in reset", int'(charge), 0);
    chk("R1 discharge in reset", int'(discharge), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 charge", int'(charge), 0);
    chk("R1 discharge", int'(discharge), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 overrange", int'(overrange), 0);
    chk("R1 len", int'(len), 0);

    // vector table: R3 lengths, R8 saturation and its clearing
    for (int v = 0; v < NV; v++) begin
      run_window(VEC_GAP[v], 1'b1, -10);
      chk("R3 window length", int'(len), VEC_LEN[v]);
      chk("R8 overrange flag", int'(overrange), VEC_OVR[v]);
    end
    chk("R8 ceiling value", MAXC, 255);

    // R9: lone compared edge
    begin
      int i0;
      int l0;
      i0 = irq_seen;
      l0 = int'(len);
      cmp_p = 1'b1;
      repeat (4) @(negedge clk);
      cmp_p = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 no irq", irq_seen - i0, 0);
      chk("R9 charge", int'(charge), 0);
      chk("R9 discharge", int'(discharge), 1);
      chk("R9 len", int'(len), l0);
    end

    // R6: acknowledge during charging is ignored
    run_window(12, 1'b0, 5);
    chk("R6 discharge stays off", int'(discharge), 0);
    chk("R6 len", int'(len), 12);

    // R7: reference edge during hold
    begin
      int i0;
      i0 = irq_seen;
      ref_p = 1'b1;
      repeat (4) @(negedge clk);
      ref_p = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 overrun set", int'(overrun), 1);
      chk("R7 charge", int'(charge), 0);
      chk("R7 len kept", int'(len), 12);
      chk("R7 no irq", irq_seen - i0, 0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R5 released", int'(discharge), 1);
      run_window(7, 1'b1, -10);
      chk("R7 overrun sticky", int'(overrun), 1);
      chk("R3 len after overrun", int'(len), 7);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule